// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block is a blocking data cache that sits between a processor port that carries single words and a slower memory port that carries whole lines. Each byte address is split into a tag, a line index and an offset. The line named by the index is looked up, and the stored tag and valid bit decide whether the access hits. Writes that hit change only the cached copy and mark the line as modified. A line is written to memory only when another line that maps to the same index displaces it. A write that misses first brings the line in and then merges the word into it.

Both ports use a request/ready handshake. The processor raises its request and holds it until the cache returns a one-cycle ready pulse. A hit completes on the second rising edge after the request is seen. A miss uses the memory port. For a clean miss this is one line read. For a modified victim it is one line write of the victim, followed by one line read. The access then completes as a hit. Words are packed into a line with word 0 in memory data bits [31:0] and word 3 in bits [127:96].

Top module: `wb_dcache`

## Requirements
- R1: A 32-bit byte address splits into offset [3:0], a 10-bit index [13:4] and an 18-bit tag [31:14]. Address bits [3:2] select one of 4 words in a 128-bit line. Addresses that differ only in bits [3:0] use the same line.
- R2: After reset, every line is invalid and cpu_ready and mem_valid are low. The first access to any line is therefore a miss.
- R3: A read hit returns the selected word with cpu_ready on the second rising edge after the request is seen, and it makes no memory request.
- R4: A write hit replaces only the addressed word, marks the line modified and makes no memory request. A later read of that word returns the written value.
- R5: A miss on a line that is clean or invalid issues exactly one memory read (mem_rw=0) at {tag, index, 4'b0000}. It then completes with the fetched data, on the rising edge LAT+4 cycles after the request, where LAT is the memory latency.
- R6: A miss on a valid, modified line first issues one memory write (mem_rw=1) at {old tag, index, 4'b0000} carrying the old line's contents. The next cycle after its mem_ready, it issues the read of the new line.
- R7: A write miss fetches the line and then merges the word into it. The other three words keep their memory values and the line is left modified.
- R8: A refill makes the line valid and not modified. Displacing a line that was only refilled and read causes no memory write.
- R9: The cache is blocking. cpu_ready is a single-cycle pulse for each request, and memory traffic has ended when it rises.
- R10: While mem_valid is high and mem_ready is low, mem_addr, mem_rw and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_rw | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with cpu_ready on a read |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request present |
| mem_rw | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Line returned by memory |
| mem_ready | input | 1 | One-cycle memory completion pulse |

## Verification
The assertions assume that the processor holds cpu_valid, cpu_rw, cpu_addr and cpu_wdata unchanged from the moment it raises a request until it sees cpu_ready. They also assume that memory gives exactly one single-cycle mem_ready per request it has taken, and never gives one unasked. The bench's processor driver changes its request only on the falling edge at which it sees the ready pulse. Its memory responder takes a request, counts a fixed latency, then pulses ready once. After that pulse it skips one falling edge before it looks at mem_valid again, so a held request is never answered twice.

// File: rtl/wb_dcache_pkg.sv
package wb_dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_COMPARE   = 2'd1,
    ST_WRITEBACK = 2'd2,
    ST_ALLOCATE  = 2'd3
  } ctrl_state_e;
endpackage

// File: rtl/wb_dcache_tags.sv
// Tag array (block-RAM style, write-first registered read) plus valid/modified flags.
module wb_dcache_tags #(
  parameter int NUM_LINES = 1024,
  parameter int IDX_W     = 10,
  parameter int TAG_W     = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] addr,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_set,
  output logic [TAG_W-1:0] tag_q,
  output logic             valid_o,
  output logic             dirty_o
);
  logic [TAG_W-1:0]     tag_mem [NUM_LINES];
  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_mem[addr] <= fill_tag;
      tag_q         <= fill_tag;
    end else begin
      tag_q <= tag_mem[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[addr] <= 1'b1;
      dirty_q[addr] <= 1'b0;
    end else if (dirty_set) begin
      dirty_q[addr] <= 1'b1;
    end
  end

  assign valid_o = valid_q[addr];
  assign dirty_o = dirty_q[addr];
endmodule

// File: rtl/wb_dcache_lines.sv
// Line data array: one RAM per word lane so a single word can be written.
module wb_dcache_lines #(
  parameter int NUM_LINES  = 1024,
  parameter int IDX_W      = 10,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic                  clk,
  input  logic [IDX_W-1:0]      addr,
  input  logic [LINE_WORDS-1:0] we_mask,
  input  logic [LINE_W-1:0]     wdata,
  output logic [LINE_W-1:0]     q
);
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_lane
    logic [WORD_W-1:0] lane_mem [NUM_LINES];
    always_ff @(posedge clk) begin
      if (we_mask[w]) begin
        lane_mem[addr]        <= wdata[w*WORD_W +: WORD_W];
        q[w*WORD_W +: WORD_W] <= wdata[w*WORD_W +: WORD_W];
      end else begin
        q[w*WORD_W +: WORD_W] <= lane_mem[addr];
      end
    end
  end
endmodule

// File: rtl/wb_dcache_ctrl.sv
// Sequencer: request capture, hit test, victim write-back and refill.
module wb_dcache_ctrl
  import wb_dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int IDX_W      = 10,
  parameter int TAG_W      = 18,
  parameter int BYTE_OFF_W = 2,
  parameter int WSEL_W     = 2,
  localparam int OFF_W     = BYTE_OFF_W + WSEL_W,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cpu_valid,
  input  logic                  cpu_rw,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [WORD_W-1:0]     cpu_wdata,
  output logic [WORD_W-1:0]     cpu_rdata,
  output logic                  cpu_ready,
  output logic                  mem_valid,
  output logic                  mem_rw,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [LINE_W-1:0]     mem_wdata,
  input  logic [LINE_W-1:0]     mem_rdata,
  input  logic                  mem_ready,
  output logic [IDX_W-1:0]      store_idx,
  input  logic [TAG_W-1:0]      tag_i,
  input  logic                  valid_i,
  input  logic                  dirty_i,
  input  logic [LINE_W-1:0]     line_i,
  output logic                  fill_en,
  output logic [TAG_W-1:0]      fill_tag,
  output logic                  dirty_set,
  output logic [LINE_WORDS-1:0] line_we_mask,
  output logic [LINE_W-1:0]     line_wdata
);
  ctrl_state_e state_q;
  logic [ADDR_W-1:BYTE_OFF_W] req_q;
  logic [WORD_W-1:0]          req_wdata_q;
  logic                       req_wr_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic              hit;
  logic              unused_byte_bits;

  assign unused_byte_bits = ^cpu_addr[BYTE_OFF_W-1:0];

  assign req_tag  = req_q[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_q[OFF_W +: IDX_W];
  assign req_wsel = req_q[BYTE_OFF_W +: WSEL_W];
  assign hit      = valid_i && (tag_i == req_tag);

  assign store_idx = (state_q == ST_IDLE) ? cpu_addr[OFF_W +: IDX_W] : req_idx;
  assign fill_tag  = req_tag;

  always_comb begin
    fill_en      = 1'b0;
    dirty_set    = 1'b0;
    line_we_mask = '0;
    line_wdata   = {LINE_WORDS{req_wdata_q}};
    if (state_q == ST_COMPARE && hit && req_wr_q) begin
      line_we_mask = LINE_WORDS'(1) << req_wsel;
      dirty_set    = 1'b1;
    end else if (state_q == ST_ALLOCATE && mem_ready) begin
      line_we_mask = '1;
      line_wdata   = mem_rdata;
      fill_en      = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_q       <= '0;
      req_wdata_q <= '0;
      req_wr_q    <= 1'b0;
      cpu_rdata   <= '0;
      cpu_ready   <= 1'b0;
      mem_valid   <= 1'b0;
      mem_rw      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_valid) begin
            req_q       <= cpu_addr[ADDR_W-1:BYTE_OFF_W];
            req_wdata_q <= cpu_wdata;
            req_wr_q    <= cpu_rw;
            state_q     <= ST_COMPARE;
          end
        end
        ST_COMPARE: begin
          if (hit) begin
            if (!req_wr_q) cpu_rdata <= line_i[req_wsel*WORD_W +: WORD_W];
            cpu_ready <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (valid_i && dirty_i) begin
            mem_valid <= 1'b1;
            mem_rw    <= 1'b1;
            mem_addr  <= {tag_i, req_idx, {OFF_W{1'b0}}};
            mem_wdata <= line_i;
            state_q   <= ST_WRITEBACK;
          end else begin
            mem_valid <= 1'b1;
            mem_rw    <= 1'b0;
            mem_addr  <= {req_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            state_q   <= ST_ALLOCATE;
          end
        end
        ST_WRITEBACK: begin
          if (mem_ready) begin
            mem_rw   <= 1'b0;
            mem_addr <= {req_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            state_q  <= ST_ALLOCATE;
          end
        end
        ST_ALLOCATE: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            state_q   <= ST_COMPARE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 1024,
  localparam int BYTE_OFF_W = $clog2(WORD_W / 8),
  localparam int WSEL_W     = $clog2(LINE_WORDS),
  localparam int OFF_W      = BYTE_OFF_W + WSEL_W,
  localparam int IDX_W      = $clog2(NUM_LINES),
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W     = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_rw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  logic [IDX_W-1:0]      store_idx;
  logic [TAG_W-1:0]      tag_q;
  logic                  valid_w;
  logic                  dirty_w;
  logic [LINE_W-1:0]     line_q;
  logic                  fill_en;
  logic [TAG_W-1:0]      fill_tag;
  logic                  dirty_set;
  logic [LINE_WORDS-1:0] line_we_mask;
  logic [LINE_W-1:0]     line_wdata;

  wb_dcache_tags #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk(clk), .rst(rst), .addr(store_idx),
    .fill_en(fill_en), .fill_tag(fill_tag), .dirty_set(dirty_set),
    .tag_q(tag_q), .valid_o(valid_w), .dirty_o(dirty_w)
  );

  wb_dcache_lines #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)
  ) u_lines (
    .clk(clk), .addr(store_idx), .we_mask(line_we_mask),
    .wdata(line_wdata), .q(line_q)
  );

  wb_dcache_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .IDX_W(IDX_W),
    .TAG_W(TAG_W), .BYTE_OFF_W(BYTE_OFF_W), .WSEL_W(WSEL_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_rw(mem_rw), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .store_idx(store_idx), .tag_i(tag_q), .valid_i(valid_w), .dirty_i(dirty_w),
    .line_i(line_q), .fill_en(fill_en), .fill_tag(fill_tag), .dirty_set(dirty_set),
    .line_we_mask(line_we_mask), .line_wdata(line_wdata)
  );
endmodule

// File: rtl/wb_dcache_chk.sv
module wb_dcache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 10,
  parameter int LINE_W = 128
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:OFF_W]   req_line,
  input logic                    cpu_ready,
  input logic                    mem_valid,
  input logic                    mem_rw,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic [LINE_W-1:0]       mem_wdata,
  input logic                    mem_ready
);
  localparam int TAG_LO = OFF_W + IDX_W;

  // R9: completion is a single-cycle pulse
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R9: no memory request is outstanding when the access completes
  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_valid);

  // R10: memory request fields hold until the memory answers
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_rw) && $stable(mem_wdata)));

  // R5: memory addresses are line aligned
  p_line_align_r5: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

  // R5: a line read targets the line of the held processor request
  p_fetch_line_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_rw) |-> (mem_addr[ADDR_W-1:OFF_W] == req_line));

  // R6: a write-back uses the same index and a different tag
  p_victim_line_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_rw) |-> (mem_addr[TAG_LO-1:OFF_W] == req_line[TAG_LO-1:OFF_W] &&
                               mem_addr[ADDR_W-1:TAG_LO] != req_line[ADDR_W-1:TAG_LO]));

  // R6: the read follows the write-back directly
  p_wb_then_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_rw && mem_ready) |=> (mem_valid && !mem_rw));
endmodule

bind wb_dcache wb_dcache_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst(rst), .req_line(cpu_addr[ADDR_W-1:OFF_W]),
  .cpu_ready(cpu_ready), .mem_valid(mem_valid), .mem_rw(mem_rw),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/wb_dcache_tb_top.sv
module wb_dcache_tb_top;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_valid = 1'b0;
  logic         cpu_rw = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready;
  logic         mem_valid;
  logic         mem_rw;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  always #5 clk = ~clk;

  wb_dcache dut_i (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_rw(mem_rw), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // ---------------- reference memory and cache state ----------------
  logic [31:0] ref_word [logic [31:0]];
  logic [31:0] mem_word [logic [31:0]];
  bit          ref_valid [int];
  bit          ref_dirty [int];
  logic [17:0] ref_tag [int];

  function automatic logic [31:0] init_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0F1E_2D3C;
  endfunction

  function automatic logic [31:0] ref_get(input logic [31:0] a);
    logic [31:0] k;
    k = {a[31:2], 2'b00};
    return ref_word.exists(k) ? ref_word[k] : init_word(k);
  endfunction

  function automatic logic [31:0] mem_get(input logic [31:0] a);
    return mem_word.exists(a) ? mem_word[a] : init_word(a);
  endfunction

  // ---------------- memory responder ----------------
  int           wb_cnt = 0;
  int           rd_cnt = 0;
  logic [31:0]  last_wb_addr = '0;
  logic [31:0]  last_rd_addr = '0;
  logic [127:0] last_wb_data = '0;
  bit           busy = 0;
  int           cnt = 0;
  logic [31:0]  lat_addr;
  logic         lat_rw;
  logic [127:0] lat_wd;

  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0;
      busy = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (!busy) begin
      if (mem_valid) begin
        busy = 1; cnt = LAT;
        lat_addr = mem_addr; lat_rw = mem_rw; lat_wd = mem_wdata;
      end
    end else if (cnt > 1) begin
      cnt--;
    end else begin
      busy = 0;
      chk(mem_valid && mem_addr == lat_addr && mem_rw == lat_rw && mem_wdata == lat_wd,
          "R10", "memory request held", mem_addr, lat_addr);
      if (lat_rw) begin
        for (int w = 0; w < 4; w++) mem_word[lat_addr + 32'(4*w)] = lat_wd[w*32 +: 32];
        wb_cnt++; last_wb_addr = lat_addr; last_wb_data = lat_wd;
      end else begin
        for (int w = 0; w < 4; w++) mem_rdata[w*32 +: 32] = mem_get(lat_addr + 32'(4*w));
        rd_cnt++; last_rd_addr = lat_addr;
      end
      mem_ready = 1'b1;
    end
  end

  // ---------------- processor access with per-cycle comparison ----------------
  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input string rq);
    int idx;
    logic [17:0] tg;
    bit v, hit, ev;
    int exp_cyc, wb0, rd0;
    logic [31:0] old_line;
    idx = int'(a[13:4]);
    tg  = a[31:14];
    v   = ref_valid.exists(idx) && ref_valid[idx];
    hit = v && ref_tag[idx] == tg;
    ev  = v && !hit && ref_dirty[idx];
    old_line = v ? {ref_tag[idx], a[13:4], 4'h0} : 32'h0;
    exp_cyc = hit ? 2 : (ev ? 6 + 2*LAT : 4 + LAT);
    wb0 = wb_cnt; rd0 = rd_cnt;
    cpu_valid = 1'b1; cpu_rw = wr; cpu_addr = a; cpu_wdata = wd;
    for (int c = 1; c <= exp_cyc; c++) begin
      @(negedge clk);
      if (c < exp_cyc) chk(cpu_ready == 1'b0, "R9", "no ready before completion", 32'(cpu_ready), 0);
    end
    chk(cpu_ready == 1'b1, rq, "ready at predicted cycle", 32'(cpu_ready), 1);
    for (int k = 0; k < 500 && !cpu_ready; k++) @(negedge clk);
    if (!wr) chk(cpu_rdata == ref_get(a), rq, "read word", cpu_rdata, ref_get(a));
    cpu_valid = 1'b0;
    chk(wb_cnt - wb0 == int'(ev), rq, "write-back count", 32'(wb_cnt - wb0), 32'(ev));
    chk(rd_cnt - rd0 == int'(!hit), rq, "line read count", 32'(rd_cnt - rd0), 32'(!hit));
    if (ev) begin
      chk(last_wb_addr == old_line, "R6", "write-back address", last_wb_addr, old_line);
      for (int w = 0; w < 4; w++)
        chk(last_wb_data[w*32 +: 32] == ref_get(old_line + 32'(4*w)), "R6", "write-back word",
            last_wb_data[w*32 +: 32], ref_get(old_line + 32'(4*w)));
    end
    if (!hit) chk(last_rd_addr == {a[31:4], 4'h0}, "R5", "refill address", last_rd_addr, {a[31:4], 4'h0});
    if (wr) ref_word[{a[31:2], 2'b00}] = wd;
    ref_dirty[idx] = hit ? (ref_dirty[idx] | wr) : wr;
    ref_valid[idx] = 1;
    ref_tag[idx]   = tg;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] a0, b0, c0, d0, seed, ra;
    a0 = 32'h0000_1230;
    b0 = a0 + 32'h0000_4000;
    c0 = 32'h0004_5670;
    d0 = c0 + 32'h0010_0000;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_ready == 1'b0, "R2", "ready low after reset", 32'(cpu_ready), 0);
    chk(mem_valid == 1'b0, "R2", "no memory request after reset", 32'(mem_valid), 0);

    access(0, a0, 0, "R2");                  // cold miss
    access(0, a0 + 4, 0, "R1");              // same line, word 1
    access(0, a0 + 32'hC, 0, "R3");          // read hit, word 3
    access(0, a0 + 32'hE, 0, "R1");          // byte bits ignored
    access(1, a0 + 8, 32'hDEAD_BEEF, "R4");  // write hit
    access(0, a0 + 8, 0, "R4");
    access(0, a0, 0, "R4");                  // neighbour word unchanged
    access(0, b0 + 4, 0, "R6");              // modified victim evicted
    access(0, a0 + 8, 0, "R8");              // clean victim, no write-back
    access(1, c0 + 4, 32'h1234_5678, "R7");  // write miss allocates
    access(0, c0, 0, "R7");
    access(0, c0 + 4, 0, "R7");
    access(0, c0 + 32'hC, 0, "R7");
    access(0, d0, 0, "R7");                  // write-miss line is modified
    access(0, c0 + 4, 0, "R5");
    access(1, 32'h0000_0000, 32'hA1A1_0000, "R1");  // index 0
    access(1, 32'h0000_3FFC, 32'hB2B2_3FF0, "R1");  // index 1023
    access(1, 32'hFFFF_FFF8, 32'hC3C3_FFFF, "R1");  // top tag, index 1023
    access(0, 32'h0000_0000, 0, "R1");
    access(0, 32'h0000_3FFC, 0, "R1");

    seed = 32'h1357_9BDF;
    for (int i = 0; i < 80; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      ra = {12'h0, seed[29:28], seed[27:26], 6'h0, seed[25:24], 2'b00, seed[23:22], 2'b00};
      access(seed[31], ra, seed ^ 32'h5555_AAAA, "R5");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule